// File: doc/BRIEF.md
# Post-Add Mantissa Normalizer

This block sits directly behind a floating-point mantissa adder/subtractor. It takes the raw sum, which is one bit wider than the mantissa so that a carry-out from addition fits in its top bit. It returns three things: a mantissa with its leading one moved into the most significant position, a signed shift count that the exponent logic adds to the exponent, and a flag that marks an exactly-zero result.

The leading-one search treats the carry-out bit as position -1. A one there means the sum must shift right by one place. A one first found further down means the sum must shift left by the number of zero bits above it. The search builds a one-hot position vector plus a separate all-zero indicator, then encodes the position into a two's-complement count. All results go through one register stage, with a valid bit running beside them. Guard, round and sticky bits are not handled here, and neither is the exponent arithmetic.

Top module: `post_add_normalizer`

## Requirements
- R1: When `raw_mant[24]` is 1, the count is -1 (`6'b111111`) and the mantissa is `raw_mant[24:1]`, whatever the lower bits hold.
- R2: When `raw_mant[24]` is 0 and the highest set bit is `raw_mant[23-i]`, the count is i and the mantissa is `raw_mant[23:0]` shifted left by i, with zeros filling from the right.
- R3: The count is a 6-bit two's-complement number. For every nonzero input it lies in the range -1 to 23.
- R4: When all 25 input bits are 0, `is_zero` is 1 and both the mantissa and the count are 0.
- R5: When `out_valid` is 1 and `is_zero` is 0, bit 23 of the mantissa is 1.
- R6: Results appear one clock after the input is presented. `out_valid` equals the `in_valid` of the previous cycle.
- R7: While `in_valid` is 0, the mantissa, count and zero outputs keep their previous values, whatever `raw_mant` carries.
- R8: After reset, `out_valid`, `norm_mant`, `shift_cnt` and `is_zero` are all 0.
- R9: Bits below the leading one have no effect on the count. They show up in the mantissa only in their shifted positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `raw_mant` as a sum to normalize |
| raw_mant | input | 25 | Raw adder result; bit 24 is the addition carry-out |
| out_valid | output | 1 | Outputs hold a new result this cycle |
| norm_mant | output | 24 | Normalized mantissa |
| shift_cnt | output | 6 | Signed exponent adjustment: -1 for a right shift, else the left shift amount |
| is_zero | output | 1 | The raw sum was exactly zero |

## Verification
The bench walks the leading one through every position from the carry bit down to bit 0, and fills the bits below it with varying junk. An off-by-one in the position encoding would show up as a count one step off, or as a mantissa whose top bit is clear. A shifter that keeps the left-shift path for the carry case would drop the carry bit, and the bench catches that from the mantissa. The all-zero input is checked for a forced count of 0; a design that left the count floating, or tried to shift all 24 places, would fail there. Idle cycles with changing inputs are checked to leave the outputs frozen, and back-to-back inputs are checked to come out exactly one cycle later.

// File: rtl/norm_pkg.sv
package norm_pkg;

    localparam int unsigned DEF_MANT_W = 24;

    // Signed count must span -1 .. MANT_W-1.
    function automatic int unsigned cnt_width(input int unsigned mant_w);
        return $clog2(mant_w + 1) + 1;
    endfunction

endpackage

// File: rtl/norm_lead_detect.sv
module norm_lead_detect #(
    parameter int unsigned RAW_W = 25
) (
    input  logic [RAW_W-1:0] raw,
    output logic [RAW_W-1:0] onehot,
    output logic             all_zero
);

    // clear_above[k]: the k bits scanned from the top are all zero
    logic [RAW_W:0] clear_above;

    assign clear_above[0] = 1'b1;

    generate
        for (genvar k = 0; k < RAW_W; k++) begin : g_scan
            // onehot[k] corresponds to shift code k-1; k = 0 is the carry-out
            assign onehot[k]          = clear_above[k] & raw[RAW_W-1-k];
            assign clear_above[k + 1] = clear_above[k] & ~raw[RAW_W-1-k];
        end
    endgenerate

    assign all_zero = clear_above[RAW_W];

endmodule

// File: rtl/norm_shift_encode.sv
module norm_shift_encode #(
    parameter int unsigned RAW_W = 25,
    parameter int unsigned CNT_W = 6
) (
    input  logic [RAW_W-1:0] onehot,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int k = 0; k < RAW_W; k++) begin
            if (onehot[k]) begin
                cnt = cnt | CNT_W'(k - 1);
            end
        end
    end

endmodule

// File: rtl/norm_mant_shift.sv
module norm_mant_shift #(
    parameter int unsigned MANT_W = 24,
    parameter int unsigned CNT_W  = 6
) (
    input  logic [MANT_W:0]   raw,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              right,
    output logic [MANT_W-1:0] mant
);

    localparam int unsigned SH_W = CNT_W - 1;

    logic [MANT_W-1:0] stage [SH_W+1];

    assign stage[0] = raw[MANT_W-1:0];

    generate
        for (genvar s = 0; s < SH_W; s++) begin : g_stage
            assign stage[s + 1] = cnt[s] ? (stage[s] << (1 << s)) : stage[s];
        end
    endgenerate

    assign mant = right ? raw[MANT_W:1] : stage[SH_W];

endmodule

// File: rtl/post_add_normalizer.sv
module post_add_normalizer #(
    parameter int unsigned  MANT_W = norm_pkg::DEF_MANT_W,
    localparam int unsigned CNT_W  = norm_pkg::cnt_width(MANT_W),
    localparam int unsigned RAW_W  = MANT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  raw_mant,
    output logic              out_valid,
    output logic [MANT_W-1:0] norm_mant,
    output logic [CNT_W-1:0]  shift_cnt,
    output logic              is_zero
);

    typedef struct packed {
        logic              vld;
        logic [MANT_W-1:0] mant;
        logic [CNT_W-1:0]  cnt;
        logic              zero;
    } out_t;

    out_t st_d, st_q;

    logic [RAW_W-1:0]  lead_onehot;
    logic              lead_zero;
    logic [CNT_W-1:0]  enc_cnt;
    logic [MANT_W-1:0] sh_mant;

    norm_lead_detect #(.RAW_W(RAW_W)) i_lead (
        .raw      (raw_mant),
        .onehot   (lead_onehot),
        .all_zero (lead_zero)
    );

    norm_shift_encode #(.RAW_W(RAW_W), .CNT_W(CNT_W)) i_enc (
        .onehot (lead_onehot),
        .cnt    (enc_cnt)
    );

    norm_mant_shift #(.MANT_W(MANT_W), .CNT_W(CNT_W)) i_shift (
        .raw   (raw_mant),
        .cnt   (enc_cnt),
        .right (lead_onehot[0]),
        .mant  (sh_mant)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.zero = lead_zero;
            st_d.mant = lead_zero ? '0 : sh_mant;
            st_d.cnt  = lead_zero ? '0 : enc_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign norm_mant = st_q.mant;
    assign shift_cnt = st_q.cnt;
    assign is_zero   = st_q.zero;

endmodule

// File: rtl/post_add_normalizer_chk.sv
module post_add_normalizer_chk #(
    parameter int unsigned MANT_W = 24,
    parameter int unsigned CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MANT_W:0]   raw_mant,
    input logic              out_valid,
    input logic [MANT_W-1:0] norm_mant,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic              is_zero
);

    // R1
    p_carry_right_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && raw_mant[MANT_W]) |=>
            (shift_cnt == '1) && (norm_mant == $past(raw_mant[MANT_W:1])));

    // R3
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_zero) |->
            (($signed(shift_cnt) >= -1) && ($signed(shift_cnt) < $signed(MANT_W))));

    // R4
    p_zero_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero |-> ((norm_mant == '0) && (shift_cnt == '0)));

    // R4
    p_zero_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (raw_mant == '0)) |=> is_zero);

    // R5
    p_top_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_zero) |-> norm_mant[MANT_W-1]);

    // R6
    p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    p_vld_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(norm_mant) && $stable(shift_cnt) && $stable(is_zero)));

endmodule

bind post_add_normalizer post_add_normalizer_chk #(
    .MANT_W (MANT_W),
    .CNT_W  (CNT_W)
) i_chk (.*);

// File: tb/test_post_add_normalizer.sv
module test_post_add_normalizer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [24:0] raw_mant = '0;
    logic        out_valid;
    logic [23:0] norm_mant;
    logic [5:0]  shift_cnt;
    logic        is_zero;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    post_add_normalizer i_post_add_normalizer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .raw_mant  (raw_mant),
        .out_valid (out_valid),
        .norm_mant (norm_mant),
        .shift_cnt (shift_cnt),
        .is_zero   (is_zero)
    );

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected result from the requirements: scan for the leading one
    task automatic model(input logic [24:0] r, output logic [23:0] em,
                         output logic [5:0] ec, output logic ez);
        em = '0; ec = '0; ez = 1'b0;
        if (r == '0) begin
            ez = 1'b1;
        end else if (r[24]) begin
            ec = 6'b111111;
            em = r[24:1];
        end else begin
            for (int k = 23; k >= 0; k--) begin
                if (r[k] && ec == 0 && em == 0) begin
                    ec = 6'(23 - k);
                    em = r[23:0] << (23 - k);
                end
            end
        end
    endtask

    task automatic apply_one(input logic [24:0] r, input string tag);
        logic [23:0] em;
        logic [5:0]  ec;
        logic        ez;
        model(r, em, ec, ez);
        @(negedge clk);
        in_valid = 1'b1;
        raw_mant = r;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {tag, " R6 valid"}, 32'(out_valid), 32'd1);
        check(norm_mant == em,   {tag, " mant"},     32'(norm_mant), 32'(em));
        check(shift_cnt == ec,   {tag, " count"},    32'(shift_cnt), 32'(ec));
        check(is_zero == ez,     {tag, " zero"},     32'(is_zero),   32'(ez));
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R8 out_valid", 32'(out_valid), 0);
        check(norm_mant == '0,   "R8 norm_mant", 32'(norm_mant), 0);
        check(shift_cnt == '0,   "R8 shift_cnt", 32'(shift_cnt), 0);
        check(is_zero == 1'b0,   "R8 is_zero",   32'(is_zero),   0);
    endtask

    task automatic t_carry();
        apply_one(25'h1000000, "R1 carry only");
        apply_one(25'h1FFFFFF, "R1 carry all ones");
        for (int n = 0; n < 6; n++) begin
            apply_one({1'b1, 24'(next_rand())}, "R1 carry junk");
        end
    endtask

    task automatic t_left_all();
        for (int i = 0; i <= 23; i++) begin
            logic [24:0] lead = 25'd1 << (23 - i);
            logic [24:0] below = (lead - 25'd1) & 25'(next_rand());
            apply_one(lead, "R2 R3 lone one");
            apply_one(lead | below, "R2 R9 one with junk");
        end
    endtask

    task automatic t_zero();
        apply_one(25'h0, "R4 all zero");
        apply_one(25'h0000001, "R3 lowest bit");
        apply_one(25'h0, "R4 zero after max shift");
    endtask

    task automatic t_hold();
        logic [23:0] m0;
        logic [5:0]  c0;
        logic        z0;
        apply_one(25'h0034567, "R7 setup");
        m0 = norm_mant; c0 = shift_cnt; z0 = is_zero;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            raw_mant = (n == 0) ? 25'h0 : 25'(next_rand());
            in_valid = 1'b0;
            @(negedge clk);
            check(out_valid == 1'b0, "R7 R6 idle valid", 32'(out_valid), 0);
            check(norm_mant == m0, "R7 held mant", 32'(norm_mant), 32'(m0));
            check(shift_cnt == c0, "R7 held count", 32'(shift_cnt), 32'(c0));
            check(is_zero == z0, "R7 held zero", 32'(is_zero), 32'(z0));
        end
    endtask

    task automatic t_stream();
        logic [24:0] seq [4] = '{25'h1800000, 25'h0000300, 25'h0, 25'h0400001};
        logic [23:0] em;
        logic [5:0]  ec;
        logic        ez;
        @(negedge clk);
        in_valid = 1'b1;
        raw_mant = seq[0];
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            model(seq[n-1], em, ec, ez);
            check(out_valid == 1'b1, "R6 stream valid", 32'(out_valid), 1);
            check(norm_mant == em, "R6 stream mant", 32'(norm_mant), 32'(em));
            check(shift_cnt == ec, "R6 stream count", 32'(shift_cnt), 32'(ec));
            check(is_zero == ez, "R6 stream zero", 32'(is_zero), 32'(ez));
            if (n < 4) raw_mant = seq[n];
            else in_valid = 1'b0;
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R6 stream end", 32'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry();
        t_left_all();
        t_zero();
        t_hold();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule